// File: doc/BRIEF.md
# Sub-word load/store alignment unit

This block sits between a processor's memory stage and a 32-bit word-addressed data memory. Each request carries an opcode, a base register value, a signed 16-bit displacement and the register value to store. From these the unit forms the effective byte address, the word address sent to memory, four byte-lane write enables and the lane-replicated write data. Memory is expected to return the read word one clock after a read is requested. The unit keeps the access width, signedness and byte offset of that load for one cycle. When the word comes back, it picks out the addressed byte, halfword or word and sign- or zero-extends it to 32 bits.

Bytes are numbered big-endian inside a word. Byte offset 0 is bits 31..24 and offset 3 is bits 7..0. Halfword offset 0 is bits 31..16 and offset 2 is bits 15..0. Write-enable bit i covers data bits 8i+7..8i, so byte offset k maps to enable bit 3-k. A halfword access with an odd address or a word access whose two low address bits are not zero is flagged as misaligned. Such an access causes no write and no read. Opcodes outside the memory set are ignored.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is base plus the 16-bit displacement sign-extended to 32 bits. mem_addr carries bits 31..2 of the effective address.
- R2: The load opcodes are 0x20 (signed byte), 0x21 (signed halfword), 0x23 (word), 0x24 (unsigned byte) and 0x25 (unsigned halfword). The store opcodes are 0x28 (byte), 0x29 (halfword) and 0x2b (word). Any other opcode gives mem_we = 0, mem_re = 0 and misalign = 0, and no ld_valid follows.
- R3: A byte store drives mem_wdata with the low 8 bits of st_data repeated in all four lanes. Only enable bit 3-k is set, where k is the effective address modulo 4.
- R4: An aligned halfword store drives the low 16 bits of st_data into both halves. It sets mem_we = 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R5: An aligned word store drives mem_wdata = st_data and mem_we = 4'b1111.
- R6: A halfword access at an odd address, or a word access with nonzero low two address bits, raises misalign in the same cycle. It forces mem_we = 0 and mem_re = 0, and no ld_valid follows. A byte access is never misaligned.
- R7: An aligned load raises mem_re in its request cycle. ld_valid is high in exactly the following cycle.
- R8: A signed byte load returns the byte at offset k, taken from read-word bits 31-8k..24-8k and sign-extended.
- R9: An unsigned byte load returns that byte zero-extended.
- R10: A signed halfword load returns bits 31..16 at offset 0, or bits 15..0 at offset 2, sign-extended.
- R11: An unsigned halfword load returns that halfword zero-extended.
- R12: A word load returns the read word unchanged.
- R13: After reset and before any request, ld_valid is low.
- R14: While req_valid is low, mem_we = 0, mem_re = 0 and misalign = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| opcode | input | 6 | Memory operation code |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| st_data | input | 32 | Register value to store |
| mem_addr | output | 30 | Word address to memory |
| mem_we | output | 4 | Byte-lane write enables, bit i covers bits 8i+7..8i |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_re | output | 1 | Read request to memory |
| misalign | output | 1 | Current request is misaligned |
| mem_rd | input | 32 | Word returned by memory the cycle after mem_re |
| ld_valid | output | 1 | ld_data is valid this cycle |
| ld_data | output | 32 | Extracted and extended load result |

## Verification
The hardest cases to reach are those where the carry of base plus a negative displacement lands on a particular low-address offset. The cases of interest are a signed byte at offset 3 whose top bit is set, and a halfword that turns odd only after the addition. Uniform random operands reach each offset only one time in four and reach a set sign bit only by chance. The stimulus therefore mixes random requests with directed ones. In the directed requests the base and displacement are chosen so the sum lands on each offset. The returned memory word places 0x80-style patterns in exactly the lane being read, and the write data has distinct low bytes so a wrong lane shows at once.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    localparam int OP_W = 6;

    localparam logic [OP_W-1:0] OP_LD_BS = 6'h20;
    localparam logic [OP_W-1:0] OP_LD_HS = 6'h21;
    localparam logic [OP_W-1:0] OP_LD_W  = 6'h23;
    localparam logic [OP_W-1:0] OP_LD_BU = 6'h24;
    localparam logic [OP_W-1:0] OP_LD_HU = 6'h25;
    localparam logic [OP_W-1:0] OP_ST_B  = 6'h28;
    localparam logic [OP_W-1:0] OP_ST_H  = 6'h29;
    localparam logic [OP_W-1:0] OP_ST_W  = 6'h2b;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic      is_load;
        logic      is_store;
        logic      sign_ext;
        acc_size_e size;
    } acc_ctl_t;

    function automatic acc_ctl_t decode_op(input logic [OP_W-1:0] op);
        acc_ctl_t c;
        c = '{is_load: 1'b0, is_store: 1'b0, sign_ext: 1'b0, size: SZ_BYTE};
        case (op)
            OP_LD_BS: c = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b1, size: SZ_BYTE};
            OP_LD_HS: c = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b1, size: SZ_HALF};
            OP_LD_W:  c = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
            OP_LD_BU: c = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_BYTE};
            OP_LD_HU: c = '{is_load: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_HALF};
            OP_ST_B:  c = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_BYTE};
            OP_ST_H:  c = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_HALF};
            OP_ST_W:  c = '{is_load: 1'b0, is_store: 1'b1, sign_ext: 1'b0, size: SZ_WORD};
            default:  c = '{is_load: 1'b0, is_store: 1'b0, sign_ext: 1'b0, size: SZ_BYTE};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int OFF_W  = 2
) (
    input  logic [ADDR_W-1:0]       base,
    input  logic [DISP_W-1:0]       disp,
    output logic [ADDR_W-OFF_W-1:0] word_addr,
    output logic [OFF_W-1:0]        byte_off
);
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] eff_addr;

    assign disp_ext  = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    assign eff_addr  = base + disp_ext;
    assign word_addr = eff_addr[ADDR_W-1:OFF_W];
    assign byte_off  = eff_addr[OFF_W-1:0];
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  acc_ctl_t           ctl,
    input  logic               enable,
    input  logic [OFF_W-1:0]   byte_off,
    input  logic [DATA_W-1:0]  st_data,
    output logic [BYTES-1:0]   we,
    output logic [DATA_W-1:0]  wdata
);
    localparam int HALVES = BYTES / 2;

    logic [BYTES-1:0] lane_hit;

    // lane k (big-endian position) drives enable bit BYTES-1-k
    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        always_comb begin
            case (ctl.size)
                SZ_BYTE: lane_hit[k] = (byte_off == OFF_W'(k));
                SZ_HALF: lane_hit[k] = (byte_off[OFF_W-1:1] == (OFF_W-1)'(k / 2));
                default: lane_hit[k] = 1'b1;
            endcase
        end
        assign we[BYTES-1-k] = enable & lane_hit[k];
    end

    always_comb begin
        case (ctl.size)
            SZ_BYTE: wdata = {BYTES{st_data[7:0]}};
            SZ_HALF: wdata = {HALVES{st_data[15:0]}};
            default: wdata = st_data;
        endcase
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  acc_ctl_t          ctl,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] ld_data
);
    localparam int HALVES = BYTES / 2;

    logic [7:0]  byte_at [BYTES];
    logic [15:0] half_at [HALVES];
    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        assign byte_at[k] = rd_word[DATA_W-1-8*k -: 8];
    end
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_at[h] = rd_word[DATA_W-1-16*h -: 16];
    end

    assign sel_byte = byte_at[byte_off];
    assign sel_half = half_at[byte_off[OFF_W-1:1]];

    always_comb begin
        case (ctl.size)
            SZ_BYTE: ld_data = {{(DATA_W-8){ctl.sign_ext & sel_byte[7]}}, sel_byte};
            SZ_HALF: ld_data = {{(DATA_W-16){ctl.sign_ext & sel_half[15]}}, sel_half};
            default: ld_data = rd_word;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DISP_W = 16,
    localparam int BYTES   = DATA_W / 8,
    localparam int OFF_W   = $clog2(BYTES),
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [OP_W-1:0]     opcode,
    input  logic [ADDR_W-1:0]   base,
    input  logic [DISP_W-1:0]   disp,
    input  logic [DATA_W-1:0]   st_data,
    output logic [WADDR_W-1:0]  mem_addr,
    output logic [BYTES-1:0]    mem_we,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_re,
    output logic                misalign,
    input  logic [DATA_W-1:0]   mem_rd,
    output logic                ld_valid,
    output logic [DATA_W-1:0]   ld_data
);
    acc_ctl_t         req_ctl;
    logic [OFF_W-1:0] req_off;
    logic             off_bad;
    logic             st_go;

    acc_ctl_t         ld_ctl_q;
    logic [OFF_W-1:0] ld_off_q;
    logic             ld_valid_q;

    assign req_ctl = decode_op(opcode);

    lsu_ea_gen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .OFF_W  (OFF_W)
    ) u_ea (
        .base      (base),
        .disp      (disp),
        .word_addr (mem_addr),
        .byte_off  (req_off)
    );

    always_comb begin
        case (req_ctl.size)
            SZ_BYTE: off_bad = 1'b0;
            SZ_HALF: off_bad = req_off[0];
            default: off_bad = |req_off;
        endcase
    end

    assign misalign = req_valid & (req_ctl.is_load | req_ctl.is_store) & off_bad;
    assign st_go    = req_valid & req_ctl.is_store & ~off_bad;
    assign mem_re   = req_valid & req_ctl.is_load & ~off_bad;

    lsu_store_lanes #(
        .DATA_W (DATA_W)
    ) u_st (
        .ctl      (req_ctl),
        .enable   (st_go),
        .byte_off (req_off),
        .st_data  (st_data),
        .we       (mem_we),
        .wdata    (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid_q <= 1'b0;
            ld_ctl_q   <= '0;
            ld_off_q   <= '0;
        end else begin
            ld_valid_q <= mem_re;
            if (mem_re) begin
                ld_ctl_q <= req_ctl;
                ld_off_q <= req_off;
            end
        end
    end

    assign ld_valid = ld_valid_q;

    lsu_load_extract #(
        .DATA_W (DATA_W)
    ) u_ld (
        .ctl      (ld_ctl_q),
        .byte_off (ld_off_q),
        .rd_word  (mem_rd),
        .ld_data  (ld_data)
    );
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_align_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [OP_W-1:0] opcode,
    input logic [31:0]     st_data,
    input logic [3:0]      mem_we,
    input logic [31:0]     mem_wdata,
    input logic            mem_re,
    input logic            misalign,
    input logic            ld_valid
);
    p_idle_quiet_r14: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (mem_we == 4'b0 && !mem_re && !misalign));

    p_mis_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (mem_we == 4'b0 && !mem_re));

    p_ld_follows_r7: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> ld_valid);

    p_ld_only_after_re_r7: assert property (@(posedge clk) disable iff (rst)
        !mem_re |=> !ld_valid);

    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && opcode == OP_ST_B) |-> ($countones(mem_we) == 1 && !misalign));

    p_half_two_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && opcode == OP_ST_H && !misalign) |->
            (mem_we == 4'b1100 || mem_we == 4'b0011));

    p_word_all_lanes_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && opcode == OP_ST_W && !misalign) |->
            (mem_we == 4'b1111 && mem_wdata == st_data));

    p_reset_idle_r13: assert property (@(posedge clk)
        $past(rst) |-> !ld_valid);
endmodule

bind lsu_align_unit lsu_align_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .opcode    (opcode),
    .st_data   (st_data),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_re    (mem_re),
    .misalign  (misalign),
    .ld_valid  (ld_valid)
);

// File: tb/lsu_align_unit_tb_top.sv
module lsu_align_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] base = '0;
    logic [15:0] disp = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_rd = '0;
    logic [29:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        mem_re;
    logic        misalign;
    logic        ld_valid;
    logic [31:0] ld_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lsu_align_unit dut_i (
        .clk (clk), .rst (rst), .req_valid (req_valid), .opcode (opcode),
        .base (base), .disp (disp), .st_data (st_data), .mem_addr (mem_addr),
        .mem_we (mem_we), .mem_wdata (mem_wdata), .mem_re (mem_re),
        .misalign (misalign), .mem_rd (mem_rd), .ld_valid (ld_valid),
        .ld_data (ld_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int op_size(input logic [5:0] op); // 0 none,1 byte,2 half,4 word
        case (op)
            6'h20, 6'h24, 6'h28: return 1;
            6'h21, 6'h25, 6'h29: return 2;
            6'h23, 6'h2b:        return 4;
            default:             return 0;
        endcase
    endfunction

    function automatic bit op_load(input logic [5:0] op);
        return (op == 6'h20 || op == 6'h21 || op == 6'h23 || op == 6'h24 || op == 6'h25);
    endfunction

    function automatic bit op_store(input logic [5:0] op);
        return (op == 6'h28 || op == 6'h29 || op == 6'h2b);
    endfunction

    function automatic logic [31:0] calc_ea(input logic [31:0] b, input logic [15:0] d);
        return b + {{16{d[15]}}, d};
    endfunction

    function automatic bit calc_mis(input int sz, input logic [1:0] off);
        if (sz == 2) return off[0];
        if (sz == 4) return off != 2'd0;
        return 1'b0;
    endfunction

    function automatic logic [3:0] calc_we(input int sz, input logic [1:0] off);
        if (sz == 1) return 4'b1000 >> off;
        if (sz == 2) return off[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] calc_wdata(input int sz, input logic [31:0] d);
        if (sz == 1) return {4{d[7:0]}};
        if (sz == 2) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] calc_ld(input logic [5:0] op, input logic [1:0] off,
                                            input logic [31:0] w);
        logic [7:0]  b8;
        logic [15:0] h16;
        b8  = 8'(w >> (24 - 8 * int'(off)));
        h16 = off[1] ? w[15:0] : w[31:16];
        case (op)
            6'h20: return {{24{b8[7]}}, b8};
            6'h24: return {24'h0, b8};
            6'h21: return {{16{h16[15]}}, h16};
            6'h25: return {16'h0, h16};
            default: return w;
        endcase
    endfunction

    // one request cycle followed by one response cycle
    task automatic do_req(input logic [5:0] op, input logic [31:0] b, input logic [15:0] d,
                          input logic [31:0] sd, input logic [31:0] rdw);
        logic [31:0] ea;
        int sz;
        bit mis, is_ld, is_st;
        ea    = calc_ea(b, d);
        sz    = op_size(op);
        is_ld = op_load(op);
        is_st = op_store(op);
        mis   = (sz != 0) && calc_mis(sz, ea[1:0]);
        @(negedge clk);
        req_valid = 1'b1; opcode = op; base = b; disp = d; st_data = sd;
        #1;
        chk("R1 mem_addr", {2'b0, mem_addr}, {2'b0, ea[31:2]});
        chk("R6 misalign", {31'b0, misalign}, {31'b0, mis});
        if (is_st && !mis) begin
            chk(sz == 1 ? "R3 we" : (sz == 2 ? "R4 we" : "R5 we"),
                {28'b0, mem_we}, {28'b0, calc_we(sz, ea[1:0])});
            chk(sz == 1 ? "R3 wdata" : (sz == 2 ? "R4 wdata" : "R5 wdata"),
                mem_wdata, calc_wdata(sz, sd));
        end else begin
            chk(sz == 0 ? "R2 we" : "R6 we", {28'b0, mem_we}, 32'h0);
        end
        chk(sz == 0 ? "R2 re" : "R7 re", {31'b0, mem_re}, {31'b0, is_ld && !mis});
        @(negedge clk);
        req_valid = 1'b0; opcode = $urandom(); mem_rd = rdw;
        #1;
        chk("R14 idle we", {28'b0, mem_we}, 32'h0);
        chk("R7 ld_valid", {31'b0, ld_valid}, {31'b0, is_ld && !mis});
        if (is_ld && !mis) begin
            case (op)
                6'h20: chk("R8 ld_data", ld_data, calc_ld(op, ea[1:0], rdw));
                6'h24: chk("R9 ld_data", ld_data, calc_ld(op, ea[1:0], rdw));
                6'h21: chk("R10 ld_data", ld_data, calc_ld(op, ea[1:0], rdw));
                6'h25: chk("R11 ld_data", ld_data, calc_ld(op, ea[1:0], rdw));
                default: chk("R12 ld_data", ld_data, calc_ld(op, ea[1:0], rdw));
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] ops [8];
        ops = '{6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2b};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R13 ld_valid", {31'b0, ld_valid}, 32'h0);
        chk("R14 re", {31'b0, mem_re}, 32'h0);

        // directed: signed/unsigned byte at every offset with sign bit in that lane
        for (int k = 0; k < 4; k++) begin
            do_req(6'h20, 32'h0000_1000 + 32'(k) + 32'd8, 16'hfff8, 32'h0,
                   32'h80 << (24 - 8 * k));
            do_req(6'h24, 32'h0000_1000 + 32'(k), 16'h0, 32'h0, 32'hffff_ffff);
            do_req(6'h28, 32'h0000_2000, 16'(k), 32'h1234_56a5, 32'h0);
        end
        // halfwords at both aligned offsets, then odd
        do_req(6'h21, 32'h100, 16'h0002, 32'h0, 32'h1234_8001);
        do_req(6'h21, 32'h100, 16'h0000, 32'h0, 32'hfedc_0001);
        do_req(6'h25, 32'h102, 16'h0000, 32'h0, 32'h1234_8001);
        do_req(6'h29, 32'h104, 16'hfffe, 32'hdead_beef, 32'h0);
        do_req(6'h29, 32'h105, 16'hfffc, 32'hdead_beef, 32'h0);
        do_req(6'h21, 32'h003, 16'h0000, 32'h0, 32'h1111_2222);
        // words aligned and misaligned, sum crossing zero
        do_req(6'h2b, 32'h0000_0004, 16'hfffc, 32'hcafe_f00d, 32'h0);
        do_req(6'h23, 32'h0000_0010, 16'h0002, 32'h0, 32'h5555_aaaa);
        do_req(6'h23, 32'hffff_fff0, 16'h0010, 32'h0, 32'h8765_4321);
        // non-memory opcodes
        do_req(6'h00, 32'h1, 16'h1, 32'hffff_ffff, 32'h0);
        do_req(6'h22, 32'h1, 16'h0, 32'hffff_ffff, 32'h0);

        for (int i = 0; i < 400; i++) begin
            logic [5:0] op;
            op = ((i % 16) == 15) ? 6'($urandom()) : ops[$urandom_range(0, 7)];
            do_req(op, $urandom(), 16'($urandom()), $urandom(), $urandom());
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule